// File: doc/BRIEF.md
# Dual-Rate Parallel-to-Serial Converter

This block turns a parallel word into a serial bit stream. Words are presented on a slow clock (`clk_div_i`). That clock is derived from the fast clock (`clk_i`), with its rising edges coinciding with fast rising edges. Each word is then shifted out on the fast clock.

In single-rate mode one bit leaves per fast cycle. In double-rate mode two bits leave per fast cycle. They appear on a two-bit pair: element 0 is the bit for the rising half and element 1 is the bit for the falling half.

Words wider than eight bits use two instances:
- The master carries lanes 0..7.
- A slave carries the remaining lanes and feeds them to the master through a two-bit cascade link.

Reset is asserted asynchronously. It is released through a synchronizer in the divided domain and then a second synchronizer in the fast domain. Every instance sharing the clocks and the reset pulse therefore starts its word period on the same fast edge.

Top module: `ser_p2s`

## Requirements
- R1: Lane 0 of a word is the first bit driven on `ser_o`. The remaining lanes follow in ascending index order. In double-rate mode, `ser_o[0]` carries lane 2i and `ser_o[1]` carries lane 2i+1 during the i-th fast cycle of the word.
- R2: The word period is WIDTH fast cycles (single rate) or WIDTH/2 fast cycles (double rate). A word sampled on a `clk_div_i` rising edge starts on `ser_o` right after the fast edge that coincides with the next `clk_div_i` rising edge. This holds identically for every instance that shares both clocks and `rst_ni`.
- R3: In single-rate mode both elements of `ser_o` carry the same bit.
- R4: While `rst_ni` is low, `ser_o` and `ser_fb_o` equal {SR_VAL, SR_VAL}. This applies immediately when `rst_ni` falls, without waiting for a clock edge.
- R5: After `rst_ni` rises, the output sequence is:
  - `ser_o` keeps SR_VAL up to and including the second fast edge after the second `clk_div_i` rising edge.
  - It then shows {INIT_VAL, INIT_VAL}.
  - The first word delivered is the one sampled on the third `clk_div_i` rising edge after the release.
- R6: A fast edge at which `oce_i` is low leaves `ser_o` unchanged. The word timing keeps running, so on re-enable the output shows the bit scheduled for that cycle.
- R7: `ser_fb_o` always carries the same value as `ser_o`.
- R8: With WIDTH 10 or 14 in double-rate mode, a slave's `cascade_o` drives the master's `cascade_i`. The master then emits lanes 0..7 of its own word followed by lanes 0..WIDTH-9 of the slave's word as one contiguous word.
- R9: A configuration is accepted only in these cases:
  - single rate with WIDTH 2..8;
  - double rate with WIDTH 4, 6, 8, 10 or 14;
  - SLAVE only with WIDTH above 8.

  Any other configuration stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast serial clock |
| clk_div_i | input | 1 | Divided parallel clock, edges aligned to `clk_i` rising edges |
| rst_ni | input | 1 | Active-low reset, asynchronous assert |
| oce_i | input | 1 | Output clock enable, sampled on `clk_i` |
| data_i | input | 8 | Parallel lanes; lane 0 is sent first |
| cascade_i | input | 2 | Bits from a slave (master side of a wide pair) |
| cascade_o | output | 2 | Bits leaving this instance toward a master |
| ser_o | output | 2 | Serial pair: [0] rising-half bit, [1] falling-half bit |
| ser_fb_o | output | 2 | Feedback copy of `ser_o` |

## Verification
The bench sweeps every code value through three configurations with exhaustive word streams:
- An 8-bit double-rate instance is fed with all 256 codes in a scrambled order. This exposes lane order, pair order and word-boundary placement.
- A 5-bit single-rate instance is fed with all 32 codes. This separates odd word periods from even ones and shows whether both pair halves match.
- A 10-bit master/slave pair is fed with all 1024 codes. This shows whether slave lanes land right after lane 7 and whether the two instances leave reset on the same fast edge.

Clock-enable gaps check hold versus skip behaviour. A second reset in mid-stream checks the asynchronous reset value, the initial value and the realignment.

// File: rtl/ser_p2s_pkg.sv
package ser_p2s_pkg;
  localparam int unsigned LANES       = 8;
  localparam int unsigned CASC_W      = 2;
  localparam int unsigned SYNC_STAGES = 2;

  function automatic bit cfg_ok(input int unsigned w, input bit ddr, input bit slave);
    bit ok;
    if (ddr) ok = (w == 4) || (w == 6) || (w == 8) || (w == 10) || (w == 14);
    else     ok = (w >= 2) && (w <= LANES);
    if (slave && (w <= LANES)) ok = 1'b0;
    return ok;
  endfunction

  function automatic int unsigned word_ratio(input int unsigned w, input bit ddr);
    return ddr ? (w / 2) : w;
  endfunction

  function automatic int unsigned local_bits(input int unsigned w, input bit slave);
    if (slave) return (w > LANES) ? (w - LANES) : 2;
    return (w > LANES) ? LANES : w;
  endfunction

  // fast-domain phase that lands transfers on divided-clock rising edges
  function automatic int unsigned load_phase(input int unsigned r);
    return (r - ((SYNC_STAGES + 1) % r)) % r;
  endfunction
endpackage

// File: rtl/ser_rst_sync.sv
module ser_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/ser_load_reg.sv
module ser_load_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_div_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] word_o,
  output logic         vld_o
);
  always_ff @(posedge clk_div_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      word_o <= data_i;
      vld_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/ser_shift_core.sv
module ser_shift_core
  import ser_p2s_pkg::*;
#(
  parameter int unsigned LOCAL_W   = 8,
  parameter int unsigned STEP      = 2,
  parameter int unsigned RATIO     = 4,
  parameter bit          CASC_FILL = 1'b0,
  parameter bit          INIT_VAL  = 1'b0,
  parameter bit          SR_VAL    = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               oce_i,
  input  logic [LOCAL_W-1:0] word_i,
  input  logic               word_vld_i,
  input  logic [CASC_W-1:0]  casc_i,
  output logic [CASC_W-1:0]  casc_o,
  output logic [1:0]         ser_o,
  output logic [1:0]         fb_o
);
  localparam int unsigned    PH_W    = $clog2(RATIO);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(RATIO - 1);
  localparam logic [PH_W-1:0] PH_LOAD = PH_W'(load_phase(RATIO));

  logic [PH_W-1:0]    phase_q;
  logic [LOCAL_W-1:0] sh_q, src_w, fill_w, sh_d;
  logic               started_q, load_now, take_word;
  logic [1:0]         pair_w, ser_d, ser_q, fb_q;

  assign load_now  = (phase_q == PH_LOAD);
  assign take_word = load_now && word_vld_i;
  assign src_w     = load_now ? word_i : sh_q;

  generate
    if (CASC_FILL) begin : g_fill
      assign fill_w = LOCAL_W'(casc_i[STEP-1:0]) << (LOCAL_W - STEP);
    end else begin : g_nofill
      logic unused_casc;
      assign unused_casc = ^casc_i;
      assign fill_w      = '0;
    end
  endgenerate

  assign sh_d   = (src_w >> STEP) | fill_w;
  assign pair_w = (STEP == 2) ? src_w[1:0] : {2{src_w[0]}};
  assign casc_o = (STEP == 2) ? src_w[1:0] : {1'b0, src_w[0]};
  assign ser_d  = (take_word || started_q) ? pair_w : {2{INIT_VAL}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= '0;
      sh_q      <= '0;
      started_q <= 1'b0;
    end else begin
      phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
      sh_q    <= sh_d;
      if (take_word) started_q <= 1'b1;
    end
  end

  // separate feedback flop keeps the pad path unloaded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_q <= {2{SR_VAL}};
      fb_q  <= {2{SR_VAL}};
    end else if (oce_i) begin
      ser_q <= ser_d;
      fb_q  <= ser_d;
    end
  end

  assign ser_o = ser_q;
  assign fb_o  = fb_q;
endmodule

// File: rtl/ser_p2s.sv
module ser_p2s
  import ser_p2s_pkg::*;
#(
  parameter int unsigned WIDTH    = 8,
  parameter bit          DDR_MODE = 1'b1,
  parameter bit          SLAVE    = 1'b0,
  parameter bit          INIT_VAL = 1'b0,
  parameter bit          SR_VAL   = 1'b0
) (
  input  logic             clk_i,
  input  logic             clk_div_i,
  input  logic             rst_ni,
  input  logic             oce_i,
  input  logic [LANES-1:0] data_i,
  input  logic [CASC_W-1:0] cascade_i,
  output logic [CASC_W-1:0] cascade_o,
  output logic [1:0]       ser_o,
  output logic [1:0]       ser_fb_o
);
  localparam int unsigned STEP      = DDR_MODE ? 2 : 1;
  localparam int unsigned RATIO     = word_ratio(WIDTH, DDR_MODE);
  localparam int unsigned LOCAL_W   = local_bits(WIDTH, SLAVE);
  localparam bit          CASC_FILL = !SLAVE && (WIDTH > LANES);

  generate
    if (!cfg_ok(WIDTH, DDR_MODE, SLAVE)) begin : g_bad_cfg
      $error("ser_p2s: illegal width / rate / slave combination");
    end
    if (LOCAL_W < LANES) begin : g_spare
      logic unused_lanes;
      assign unused_lanes = ^data_i[LANES-1:LOCAL_W];
    end
  endgenerate

  logic               rst_div_n, rst_fast_n, word_vld;
  logic [LOCAL_W-1:0] word;

  ser_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_div (
    .clk_i (clk_div_i),
    .rst_ni(rst_ni),
    .rst_no(rst_div_n)
  );

  ser_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_fast (
    .clk_i (clk_i),
    .rst_ni(rst_div_n),
    .rst_no(rst_fast_n)
  );

  ser_load_reg #(.W(LOCAL_W)) u_load (
    .clk_div_i(clk_div_i),
    .rst_ni   (rst_div_n),
    .data_i   (data_i[LOCAL_W-1:0]),
    .word_o   (word),
    .vld_o    (word_vld)
  );

  ser_shift_core #(
    .LOCAL_W  (LOCAL_W),
    .STEP     (STEP),
    .RATIO    (RATIO),
    .CASC_FILL(CASC_FILL),
    .INIT_VAL (INIT_VAL),
    .SR_VAL   (SR_VAL)
  ) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_fast_n),
    .oce_i     (oce_i),
    .word_i    (word),
    .word_vld_i(word_vld),
    .casc_i    (cascade_i),
    .casc_o    (cascade_o),
    .ser_o     (ser_o),
    .fb_o      (ser_fb_o)
  );
endmodule

// File: rtl/ser_p2s_chk.sv
module ser_p2s_chk #(
  parameter bit DDR_MODE = 1'b1,
  parameter bit SR_VAL   = 1'b0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       oce_i,
  input logic [1:0] ser_o,
  input logic [1:0] ser_fb_o
);
  AST_RST_VALUE: assert property (@(posedge clk_i)
    !rst_ni |=> (ser_o == {2{SR_VAL}})); // R4

  AST_OCE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oce_i |=> $stable(ser_o)); // R6

  AST_FB_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_fb_o == ser_o); // R7

  generate
    if (!DDR_MODE) begin : g_sdr
      AST_SDR_DUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ser_o[0] == ser_o[1]); // R3
    end
  endgenerate
endmodule

bind ser_p2s ser_p2s_chk #(.DDR_MODE(DDR_MODE), .SR_VAL(SR_VAL)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .oce_i   (oce_i),
  .ser_o   (ser_o),
  .ser_fb_o(ser_fb_o)
);

// File: tb/sim_ser_p2s.sv
module sim_ser_p2s;
  import ser_p2s_pkg::*;

  logic clk = 1'b0;
  always #10ns clk = ~clk;

  int unsigned k = 0;
  logic div4 = 1'b1, div5 = 1'b1;
  always @(posedge clk) begin
    k    <= k + 1;
    div4 <= ((k + 1) % 4) < 2;
    div5 <= ((k + 1) % 5) < 2;
  end

  logic       rst_n = 1'b1, oce0 = 1'b1;
  logic [7:0] d0 = '0, d1 = '0, d2 = '0, d3 = '0;
  logic [1:0] s0, f0, s1, f1, s2, f2, s3, f3;
  logic [1:0] co0, co1, co2, co3;

  ser_p2s #(.WIDTH(8), .DDR_MODE(1'b1), .SLAVE(1'b0), .INIT_VAL(1'b1), .SR_VAL(1'b0)) u0 (
    .clk_i(clk), .clk_div_i(div4), .rst_ni(rst_n), .oce_i(oce0), .data_i(d0),
    .cascade_i(2'b00), .cascade_o(co0), .ser_o(s0), .ser_fb_o(f0));
  ser_p2s #(.WIDTH(5), .DDR_MODE(1'b0), .SLAVE(1'b0), .INIT_VAL(1'b0), .SR_VAL(1'b1)) u1 (
    .clk_i(clk), .clk_div_i(div5), .rst_ni(rst_n), .oce_i(1'b1), .data_i(d1),
    .cascade_i(2'b00), .cascade_o(co1), .ser_o(s1), .ser_fb_o(f1));
  ser_p2s #(.WIDTH(10), .DDR_MODE(1'b1), .SLAVE(1'b0), .INIT_VAL(1'b1), .SR_VAL(1'b1)) u2 (
    .clk_i(clk), .clk_div_i(div5), .rst_ni(rst_n), .oce_i(1'b1), .data_i(d2),
    .cascade_i(co3), .cascade_o(co2), .ser_o(s2), .ser_fb_o(f2));
  ser_p2s #(.WIDTH(10), .DDR_MODE(1'b1), .SLAVE(1'b1), .INIT_VAL(1'b1), .SR_VAL(1'b1)) u3 (
    .clk_i(clk), .clk_div_i(div5), .rst_ni(rst_n), .oce_i(1'b1), .data_i(d3),
    .cascade_i(2'b00), .cascade_o(co3), .ser_o(s3), .ser_fb_o(f3));

  int unsigned n_chk = 0, n_fail = 0, rel_k = 20;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s k=%0d actual=%b expected=%b", tag, k, act, exp);
    end
  endtask

  function automatic int unsigned wd(input int inst, input int unsigned c);
    case (inst)
      0:       return (c * 37) & 255;
      1:       return (c * 7) & 31;
      default: return (c * 97) & 1023;
    endcase
  endfunction

  // expected pair after fast edge kk, from the requirement timing
  function automatic logic [1:0] ideal(input int inst, input int unsigned kk, output string tag);
    int unsigned r, n1, n2, c0, c, i, w;
    bit ddr, iv, sv;
    r   = (inst == 0) ? 4 : 5;
    ddr = (inst != 1);
    iv  = (inst != 1);
    sv  = (inst == 1) || (inst == 2);
    n1  = rel_k / r + 1;
    n2  = n1 + 1;
    c0  = n1 + 2;
    tag = "R5";
    if (kk < n2 * r + 3) return {2{sv}};
    if (kk < (c0 + 1) * r) return {2{iv}};
    c = kk / r - 1;
    i = kk % r;
    w = wd(inst, c);
    tag = (inst == 0) ? "R1 R2" : (inst == 1) ? "R3 R2" : "R8 R2";
    if (ddr) return {w[2*i+1], w[2*i]};
    return {w[i], w[i]};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #4ms;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [1:0] e0, e1, e2;
    string t0, t1, t2;
    e0 = 2'b00;
    #1ns rst_n = 1'b0;

    // R9: legal configuration table
    for (int w = 1; w <= 15; w++) begin
      for (int dr = 0; dr < 2; dr++) begin
        bit exp_ok;
        exp_ok = dr ? (w == 4 || w == 6 || w == 8 || w == 10 || w == 14) : (w >= 2 && w <= 8);
        chk(cfg_ok(w, dr[0], 1'b0) == exp_ok, "R9 cfg", {1'b0, cfg_ok(w, dr[0], 1'b0)}, {1'b0, exp_ok});
      end
    end
    chk(cfg_ok(8, 1'b1, 1'b1) == 1'b0, "R9 slave8", 2'b0, 2'b0);
    chk(cfg_ok(14, 1'b1, 1'b1) == 1'b1, "R9 slave14", 2'b0, 2'b0);

    forever begin
      @(negedge clk);
      if (!rst_n) begin
        e0 = 2'b00; e1 = 2'b11; e2 = 2'b11;
        t0 = "R4"; t1 = "R4"; t2 = "R4";
      end else begin
        logic [1:0] i0;
        i0 = ideal(0, k, t0);
        if (oce0) e0 = i0;
        else t0 = "R6";
        e1 = ideal(1, k, t1);
        e2 = ideal(2, k, t2);
      end
      chk(s0 === e0, t0, s0, e0);
      chk(f0 === e0, "R7 fb0", f0, e0);
      chk(s1 === e1, t1, s1, e1);
      chk(f1 === e1, "R7 fb1", f1, e1);
      chk(s2 === e2, t2, s2, e2);
      chk(f2 === e2, "R7 fb2", f2, e2);

      if (k % 4 == 0) d0 = 8'(wd(0, k / 4 + 1));
      if (k % 5 == 0) begin
        int unsigned w2;
        w2 = wd(2, k / 5 + 1);
        d1 = 8'(wd(1, k / 5 + 1));
        d2 = w2[7:0];
        d3 = {6'b0, w2[9:8]};
      end
      oce0 = !((k >= 2003 && k < 2009) || k == 2015 || k == 2017);

      if (k == 20) begin
        rst_n = 1'b1;
        rel_k = 20;
      end
      if (k == 5700) begin
        rst_n = 1'b0;
        #2ns;
        chk(s0 === 2'b00, "R4 async u0", s0, 2'b00);
        chk(s1 === 2'b11, "R4 async u1", s1, 2'b11);
        chk(s2 === 2'b11, "R4 async u2", s2, 2'b11);
      end
      if (k == 5760) begin
        rst_n = 1'b1;
        rel_k = 5760;
      end
      if (k == 6600) finish_run();
    end
  end
endmodule